// File: doc/BRIEF.md
# Sampled IF Output Pin Multiplexer

This block drives the three parallel data pins that carry the digitised second IF to a baseband processor. Every cycle of the sample clock it takes a signed integer sample. It reduces the sample to a sign bit and a small magnitude code, and presents them on the pins in one of two layouts. A single format bit selects the layout: one carries a 1-bit magnitude, the other a 2-bit magnitude. The magnitude is found by comparing the absolute value of the sample with three programmable thresholds. The 2-bit code equals the number of thresholds that the absolute value reaches. The 1-bit magnitude uses only the middle threshold.

For bench debug, the same pins can carry internal signals instead of the sample. A test enable turns this on, and a 2-bit mode field then picks one of four signal groups: clock and calibration flags, charge-pump pulses with the serial data-out, divider outputs with a handshake flag, or the raw sign/magnitude bits in a fixed order. Every pin is a register output. Each pin therefore changes only on a sample clock edge, and a change of mode takes effect cleanly at the next edge.

Top module: `sample_pin_mux`

## Requirements
- R1: While rst_ni is low, and after its release until the first clock edge, pins_o is 3'b000.
- R2: The sign bit is 1 exactly when sample_i is negative. Zero counts as positive.
- R3: The 2-bit magnitude code equals the number of thresholds thr_i[0], thr_i[1] and thr_i[2] for which |sample_i| >= threshold. For the most negative sample, |sample_i| is taken as 2^(SAMPLE_W-1).
- R4: With test_en_i=0 and adc_mode_i=0, pins_o[2] is the magnitude code MSB, pins_o[1] is its LSB and pins_o[0] is the sign.
- R5: With test_en_i=0 and adc_mode_i=1, pins_o[2] is the sign, pins_o[1] is (|sample_i| >= thr_i[1]) and pins_o[0] is 0.
- R6: With test_en_i=1 and test_mode_i=2'b00, pins_o = {int_clk_i, cal_end_i, clk_sel_i}.
- R7: With test_en_i=1 and test_mode_i=2'b01, pins_o = {cp_up_i, cp_dn_i, sdo_i}.
- R8: With test_en_i=1 and test_mode_i=2'b10, pins_o = {fb_div_i, ref_div_i, handshake_i}.
- R9: With test_en_i=1 and test_mode_i=2'b11, pins_o = {sign, code LSB, code MSB}, using the 2-bit code of R3 whatever the value of adc_mode_i.
- R10: Every pin reflects the inputs sampled at the previous rising clock edge: one cycle of latency. A change of test_en_i, test_mode_i or adc_mode_i takes effect at the next edge, and between edges the pins hold their value.
- R11: With test_en_i=0, test_mode_i and the debug inputs have no effect on pins_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | SAMPLE_W | Signed second-IF sample |
| thr_i | input | 3 x SAMPLE_W | Magnitude thresholds, index 0 lowest |
| adc_mode_i | input | 1 | 1: 1-bit magnitude format, 0: 2-bit magnitude format |
| test_en_i | input | 1 | 1: pins carry the test bus |
| test_mode_i | input | 2 | Test bus group select |
| int_clk_i | input | 1 | Internal clock debug signal |
| cal_end_i | input | 1 | Filter calibration end flag |
| clk_sel_i | input | 1 | Clock source selected flag |
| cp_up_i | input | 1 | Charge-pump up pulse |
| cp_dn_i | input | 1 | Charge-pump down pulse |
| sdo_i | input | 1 | Serial data-out |
| fb_div_i | input | 1 | Feedback divider output |
| ref_div_i | input | 1 | Reference divider output |
| handshake_i | input | 1 | Handshake status |
| pins_o | output | 3 | Output pins, index 2 to 0 |

## Verification
A wrong select or a wrong comparator inside the block shows up at pins_o exactly one clock after the offending inputs. No deeper state can hide an error for longer. Misrouted sign or magnitude bits appear as swapped pins under one of the two formats. An off-by-one at a threshold only shows for samples that sit exactly on a threshold or just below it, and the most negative sample exposes a faulty absolute value. A select that is decoded late or combinationally shows as a pin changing one cycle early or late around a mode switch.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int NUM_THR = 3;
  localparam int CODE_W  = 2;

  typedef enum logic [1:0] {
    TB_CLOCKS   = 2'b00,
    TB_PUMP     = 2'b01,
    TB_DIVIDERS = 2'b10,
    TB_RAW      = 2'b11
  } tbus_sel_e;
endpackage

// File: rtl/spm_quantizer.sv
module spm_quantizer
  import spm_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic [SAMPLE_W-1:0]              sample_i,
  input  logic [NUM_THR-1:0][SAMPLE_W-1:0] thr_i,
  output logic                             sign_o,
  output logic [CODE_W-1:0]                code_o,
  output logic                             mid_hit_o
);
  localparam int MID = NUM_THR / 2;

  logic [SAMPLE_W-1:0] abs_val;
  logic [NUM_THR-1:0]  hit;

  assign sign_o  = sample_i[SAMPLE_W-1];
  // unsigned reinterpretation keeps the most negative value exact
  assign abs_val = sign_o ? (~sample_i + SAMPLE_W'(1)) : sample_i;

  for (genvar k = 0; k < NUM_THR; k++) begin : g_cmp
    assign hit[k] = (abs_val >= thr_i[k]);
  end

  always_comb begin
    code_o = '0;
    for (int k = 0; k < NUM_THR; k++) code_o = code_o + CODE_W'(hit[k]);
  end

  assign mid_hit_o = hit[MID];
endmodule

// File: rtl/spm_pin_sel.sv
module spm_pin_sel
  import spm_pkg::*;
(
  input  logic              test_en_i,
  input  tbus_sel_e         test_mode_i,
  input  logic              adc_mode_i,
  input  logic              sign_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              mid_hit_i,
  input  logic              int_clk_i,
  input  logic              cal_end_i,
  input  logic              clk_sel_i,
  input  logic              cp_up_i,
  input  logic              cp_dn_i,
  input  logic              sdo_i,
  input  logic              fb_div_i,
  input  logic              ref_div_i,
  input  logic              handshake_i,
  output logic [2:0]        pins_o
);
  logic [2:0] data_pins;
  logic [2:0] test_pins;

  always_comb begin
    if (adc_mode_i) data_pins = {sign_i, mid_hit_i, 1'b0};
    else            data_pins = {code_i[1], code_i[0], sign_i};
  end

  always_comb begin
    unique case (test_mode_i)
      TB_CLOCKS:   test_pins = {int_clk_i, cal_end_i, clk_sel_i};
      TB_PUMP:     test_pins = {cp_up_i, cp_dn_i, sdo_i};
      TB_DIVIDERS: test_pins = {fb_div_i, ref_div_i, handshake_i};
      default:     test_pins = {sign_i, code_i[0], code_i[1]};
    endcase
  end

  assign pins_o = test_en_i ? test_pins : data_pins;
endmodule

// File: rtl/sample_pin_mux.sv
module sample_pin_mux
  import spm_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [SAMPLE_W-1:0]              sample_i,
  input  logic [NUM_THR-1:0][SAMPLE_W-1:0] thr_i,
  input  logic                             adc_mode_i,
  input  logic                             test_en_i,
  input  logic [1:0]                       test_mode_i,
  input  logic                             int_clk_i,
  input  logic                             cal_end_i,
  input  logic                             clk_sel_i,
  input  logic                             cp_up_i,
  input  logic                             cp_dn_i,
  input  logic                             sdo_i,
  input  logic                             fb_div_i,
  input  logic                             ref_div_i,
  input  logic                             handshake_i,
  output logic [2:0]                       pins_o
);
  logic              sign;
  logic [CODE_W-1:0] code;
  logic              mid_hit;
  logic [2:0]        pins_d;
  logic [2:0]        pins_q;

  spm_quantizer #(.SAMPLE_W(SAMPLE_W)) u_quant (
    .sample_i  (sample_i),
    .thr_i     (thr_i),
    .sign_o    (sign),
    .code_o    (code),
    .mid_hit_o (mid_hit)
  );

  spm_pin_sel u_sel (
    .test_en_i   (test_en_i),
    .test_mode_i (tbus_sel_e'(test_mode_i)),
    .adc_mode_i  (adc_mode_i),
    .sign_i      (sign),
    .code_i      (code),
    .mid_hit_i   (mid_hit),
    .int_clk_i   (int_clk_i),
    .cal_end_i   (cal_end_i),
    .clk_sel_i   (clk_sel_i),
    .cp_up_i     (cp_up_i),
    .cp_dn_i     (cp_dn_i),
    .sdo_i       (sdo_i),
    .fb_div_i    (fb_div_i),
    .ref_div_i   (ref_div_i),
    .handshake_i (handshake_i),
    .pins_o      (pins_d)
  );

  // single output register: no select path reaches a pin combinationally
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pins_q <= '0;
    else         pins_q <= pins_d;
  end

  assign pins_o = pins_q;

  // checks
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  AST_SIGN_PIN0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && $past(!test_en_i && !adc_mode_i) |-> pins_o[0] == $past(sample_i[SAMPLE_W-1])); // R4
  AST_SIGN_PIN2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && $past(!test_en_i && adc_mode_i) |-> pins_o[2] == $past(sample_i[SAMPLE_W-1])); // R5
  AST_PIN0_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && $past(!test_en_i && adc_mode_i) |-> !pins_o[0]); // R5
  AST_PUMP_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && $past(test_en_i && test_mode_i == 2'b01)
      |-> pins_o == $past({cp_up_i, cp_dn_i, sdo_i})); // R7
  AST_DIV_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && $past(test_en_i && test_mode_i == 2'b10)
      |-> pins_o == $past({fb_div_i, ref_div_i, handshake_i})); // R8
  AST_RESET_PINS: assert property (@(posedge clk_i)
    !rst_ni |-> pins_o == 3'b000); // R1
endmodule

// File: tb/sample_pin_mux_tb.sv
module sample_pin_mux_tb;
  localparam int W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [W-1:0]      sample = '0;
  logic [2:0][W-1:0] thr;
  logic              adc_mode = 1'b0;
  logic              test_en = 1'b0;
  logic [1:0]        test_mode = 2'b00;
  logic int_clk = 0, cal_end = 0, clk_sel = 0, cp_up = 0, cp_dn = 0;
  logic sdo = 0, fb_div = 0, ref_div = 0, handshake = 0;
  logic [2:0]        pins;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sample_pin_mux #(.SAMPLE_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .thr_i(thr),
    .adc_mode_i(adc_mode), .test_en_i(test_en), .test_mode_i(test_mode),
    .int_clk_i(int_clk), .cal_end_i(cal_end), .clk_sel_i(clk_sel),
    .cp_up_i(cp_up), .cp_dn_i(cp_dn), .sdo_i(sdo),
    .fb_div_i(fb_div), .ref_div_i(ref_div), .handshake_i(handshake),
    .pins_o(pins)
  );

  task automatic check(input string req, input logic [2:0] exp);
    n_run++;
    if (pins !== exp) begin
      n_fail++;
      $display("FAIL %s: pins=%b expected=%b", req, pins, exp);
    end
  endtask

  function automatic int absv(input logic [W-1:0] s);
    return s[W-1] ? (1 << W) - int'(s) : int'(s);
  endfunction

  function automatic logic [1:0] code_of(input logic [W-1:0] s);
    int a = absv(s);
    return 2'((a >= int'(thr[0])) + (a >= int'(thr[1])) + (a >= int'(thr[2])));
  endfunction

  // apply at negedge, observe at following negedge (one register)
  task automatic step(input logic [W-1:0] s);
    @(negedge clk);
    sample = s;
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 in reset", 3'b000);
    sample = 8'h81; adc_mode = 1'b1;
    @(negedge clk);
    check("R1 held", 3'b000);
    rst_n = 1'b1;
    #1 check("R1 after release", 3'b000);
    adc_mode = 1'b0;
  endtask

  task automatic t_two_bit;
    logic [W-1:0] vals [9] = '{8'd0, 8'd15, 8'd16, -8'sd47, 8'd48, 8'd95, -8'sd96, 8'h80, 8'd127};
    test_en = 1'b0; adc_mode = 1'b0;
    foreach (vals[i]) begin
      logic [1:0] c;
      step(vals[i]);
      c = code_of(vals[i]);
      check("R2 R3 R4 two-bit format", {c[1], c[0], vals[i][W-1]});
    end
    step(8'd16);
    check("R3 at T1", 3'b010);
    step(-8'sd128);
    check("R3 most negative", 3'b111);
  endtask

  task automatic t_one_bit;
    logic [W-1:0] vals [5] = '{8'd47, 8'd48, -8'sd47, -8'sd48, 8'h80};
    test_en = 1'b0; adc_mode = 1'b1;
    foreach (vals[i]) begin
      step(vals[i]);
      check("R2 R5 one-bit format", {vals[i][W-1], absv(vals[i]) >= int'(thr[1]), 1'b0});
    end
  endtask

  task automatic t_test_bus;
    test_en = 1'b1;
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      test_mode = 2'b00;
      {int_clk, cal_end, clk_sel} = 3'(p);
      @(negedge clk);
      check("R6 clock group", 3'(p));
      test_mode = 2'b01;
      {cp_up, cp_dn, sdo} = 3'(7 - p);
      @(negedge clk);
      check("R7 pump group", 3'(7 - p));
      test_mode = 2'b10;
      {fb_div, ref_div, handshake} = 3'(p ^ 5);
      @(negedge clk);
      check("R8 divider group", 3'(p ^ 5));
    end
    test_mode = 2'b11; adc_mode = 1'b1;
    step(-8'sd50);
    check("R9 raw order one-bit", 3'b101);
    adc_mode = 1'b0;
    step(8'd100);
    check("R9 raw order two-bit", 3'b011);
    step(8'd20);
    check("R9 raw order code1", 3'b010);
  endtask

  task automatic t_ignore;
    test_en = 1'b0; adc_mode = 1'b0;
    step(-8'sd60);
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      test_mode = 2'(m);
      {int_clk, cal_end, clk_sel, cp_up, cp_dn, sdo, fb_div, ref_div, handshake} = 9'(m * 113);
      @(negedge clk);
      check("R11 test inputs ignored", 3'b101);
    end
  endtask

  task automatic t_latency;
    test_en = 1'b0; adc_mode = 1'b0;
    step(8'd0);
    @(negedge clk);
    sample = -8'sd100;
    #2 check("R10 no change before edge", 3'b000);
    @(negedge clk);
    check("R10 one cycle later", 3'b111);
    test_en = 1'b1; test_mode = 2'b01; {cp_up, cp_dn, sdo} = 3'b010;
    #2 check("R10 mode switch waits for edge", 3'b111);
    @(posedge clk); #1;
    check("R10 mode switch at edge", 3'b010);
    #3 check("R10 held between edges", 3'b010);
    @(negedge clk);
    adc_mode = 1'b1; test_en = 1'b0;
    @(negedge clk);
    check("R10 back to data", 3'b110);
  endtask

  initial begin
    thr[0] = 8'd16; thr[1] = 8'd48; thr[2] = 8'd96;
    t_reset();
    t_two_bit();
    t_one_bit();
    t_test_bus();
    t_ignore();
    t_latency();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule